// File: doc/BRIEF.md
# Character Refresh Memory Command Engine

This block holds the character store behind a multi-position text display. It also holds a cursor register and a five-bit display status register. A host hands it one command byte at a time through a valid strobe. The engine decodes the byte and runs it as a short sequence of clock cycles. Depending on the command, it writes a character at the cursor, fills or sweeps the whole store, moves the cursor, or loads a byte into a result register for the host to read. Each command ends with a one-cycle `done` pulse. `busy` is high from the cycle after a command is accepted until the cycle after that pulse.

The state machine has seven states:

- `ST_IDLE` waits for a command.
- `ST_DISPATCH` runs every single-cycle command and prepares the multi-cycle ones.
- `ST_FILL` writes one position per cycle for the two fill commands.
- `ST_MOVE` copies one neighbour per cycle for rotate and shift.
- `ST_TAIL` writes the end position that a rotate wraps or a shift blanks.
- `ST_FETCH` copies the character under the freshly updated cursor into the result register.
- `ST_FINISH` raises `done`.

The transitions are:

- `ST_IDLE` goes to `ST_DISPATCH` on `cmd_valid`.
- `ST_DISPATCH` goes to one of four states: `ST_FILL` (fills), `ST_MOVE` (rotates and shifts), `ST_FETCH` (cursor step, cursor load, character read) or `ST_FINISH` (everything else).
- `ST_FILL` goes to `ST_FINISH` after the last position.
- `ST_MOVE` goes to `ST_TAIL` after the second-to-last copy.
- `ST_TAIL` and `ST_FETCH` go to `ST_FINISH`.
- `ST_FINISH` goes back to `ST_IDLE`.

Top module: `chd_cmd_engine`

## Requirements
- R1: After reset, `busy`, `done` and `result` are 0. Every one of the 32 stored codes, the cursor and the status register are also 0.
- R2: `cmd_valid` is sampled only in a cycle where `busy` is low. `busy` is high from the next cycle until the cycle after `done`. A `cmd_valid` raised while `busy` is high is ignored.
- R3: `done` is a one-cycle pulse. Count from the clock edge that accepts the command; `done` is high after this many edges:
  - edge 2 for character writes, status loads, length/status/cursor reads and no-ops;
  - edge 3 for cursor steps, cursor loads and character reads;
  - edge 34 for fills, rotates and shifts.
- R4: A byte `00cccccc` stores the 6-bit code `cccccc` at the cursor. When index mode is on, the cursor then steps one place in the selected direction.
- R5: Byte 0xE0 sets every position to code 0x00. Byte 0xE1 sets every position to the blank code 0x20.
- R6: Byte 0xE2 moves each code from index i+1 to index i, and index 0 wraps into index 31. Byte 0xE3 moves each code from index i-1 to index i, and index 31 wraps into index 0.
- R7: Byte 0xE4 drops index 0, moves the others down one place and writes 0x20 into index 31. Byte 0xE5 drops index 31, moves the others up one place and writes 0x20 into index 0.
- R8: Bytes 0xE6 and 0xE7 move the cursor up or down by one, modulo 32. The result then becomes `{2'b00, code at the new cursor}`.
- R9: A byte `100aaaaa` loads the cursor with `aaaaa`. The result then becomes `{2'b00, code at that index}`.
- R10: A byte `110edcba` loads the status register with `edcba`. Bit 4 is display off, bit 3 is blink, bit 2 is cursor display, bit 1 is index mode and bit 0 is direction (1 = up). Byte 0xED returns `{3'b000, status}`.
- R11: Byte 0xEA first steps the cursor in the selected direction, if index mode is on. It then returns `{2'b00, code at cursor}`. With index mode off the cursor does not move.
- R12: Byte 0xEB returns 0x1F. Byte 0xEF returns `{3'b000, cursor}`.
- R13: The following bytes change no stored code, cursor, status or result, and finish with `done`:
  - patterns `010xxxxx`, `011xxxxx` and `101xxxxx`;
  - bytes 0xE8, 0xE9, 0xEC and 0xEE;
  - bytes 0xF0 to 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command byte present; taken only while `busy` is low |
| cmd_byte | input | 8 | Command opcode and operand |
| busy | output | 1 | A command is being executed |
| done | output | 1 | One-cycle pulse at the end of each command |
| result | output | 8 | Output register loaded by read-type commands |

## Verification
A wrong cursor or store entry stays hidden until a read-type command selects that location. The bench therefore reads all 32 positions back through cursor loads after every command that touches the store. Any corrupted code shows up in `result` three cycles after the load that addresses it. A cursor that steps the wrong way, or fails to wrap, shows up in the very next read of the cursor address. A state machine that stays in a sweep state too long or too briefly changes the `done` latency, which is measured on every command. A command wrongly accepted while `busy` is high shows up as an extra `done` pulse or as store contents that differ after the fill it overlapped.

// File: rtl/chd_pkg.sv
package chd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DISPATCH,
        ST_FILL,
        ST_MOVE,
        ST_TAIL,
        ST_FETCH,
        ST_FINISH
    } chd_state_t;

    typedef enum logic [3:0] {
        OP_PUT,
        OP_WIPE,
        OP_BLANKFILL,
        OP_ROT_L,
        OP_ROT_R,
        OP_SHF_L,
        OP_SHF_R,
        OP_CUR_UP,
        OP_CUR_DN,
        OP_READ,
        OP_LEN,
        OP_STAT,
        OP_WHERE,
        OP_SEEK,
        OP_SETSTAT,
        OP_NOP
    } chd_op_t;

    function automatic chd_op_t chd_classify(input logic [7:0] op);
        chd_op_t c;
        c = OP_NOP;
        if (op[7:6] == 2'b00) begin
            c = OP_PUT;
        end else if (op[7:5] == 3'b100) begin
            c = OP_SEEK;
        end else if (op[7:5] == 3'b110) begin
            c = OP_SETSTAT;
        end else if (op[7:4] == 4'b1110) begin
            unique case (op[3:0])
                4'h0:    c = OP_WIPE;
                4'h1:    c = OP_BLANKFILL;
                4'h2:    c = OP_ROT_L;
                4'h3:    c = OP_ROT_R;
                4'h4:    c = OP_SHF_L;
                4'h5:    c = OP_SHF_R;
                4'h6:    c = OP_CUR_UP;
                4'h7:    c = OP_CUR_DN;
                4'hA:    c = OP_READ;
                4'hB:    c = OP_LEN;
                4'hD:    c = OP_STAT;
                4'hF:    c = OP_WHERE;
                default: c = OP_NOP;
            endcase
        end
        return c;
    endfunction

endpackage

// File: rtl/chd_decode.sv
module chd_decode
    import chd_pkg::*;
(
    input  logic [7:0] op,
    output chd_op_t    cls
);
    always_comb begin
        cls = chd_classify(op);
    end
endmodule

// File: rtl/chd_cursor.sv
module chd_cursor #(
    parameter int DEPTH = 32,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          step,
    input  logic          up,
    output logic [AW-1:0] cur
);
    localparam logic [AW-1:0] TOP = AW'(DEPTH - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur <= '0;
        end else if (load) begin
            cur <= load_val;
        end else if (step) begin
            if (up) begin
                cur <= (cur == TOP) ? '0 : cur + AW'(1);
            end else begin
                cur <= (cur == '0) ? TOP : cur - AW'(1);
            end
        end
    end
endmodule

// File: rtl/chd_charmem.sv
module chd_charmem #(
    parameter int DEPTH  = 32,
    parameter int CODE_W = 6,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [CODE_W-1:0] wdata,
    input  logic [AW-1:0]     raddr_a,
    output logic [CODE_W-1:0] rdata_a,
    input  logic [AW-1:0]     raddr_b,
    output logic [CODE_W-1:0] rdata_b
);
    logic [CODE_W-1:0] words [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                words[i] <= '0;
            end
        end else if (we) begin
            words[waddr] <= wdata;
        end
    end

    always_comb begin
        rdata_a = words[raddr_a];
        rdata_b = words[raddr_b];
    end
endmodule

// File: rtl/chd_cmd_engine.sv
module chd_cmd_engine
    import chd_pkg::*;
#(
    parameter int              DEPTH      = 32,
    parameter int              CODE_W     = 6,
    parameter logic [CODE_W-1:0] BLANK_CODE = 6'h20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [7:0] cmd_byte,
    output logic       busy,
    output logic       done,
    output logic [7:0] result
);
    localparam int AW = $clog2(DEPTH);
    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);
    localparam logic [AW-1:0] PENULT   = AW'(DEPTH - 2);
    localparam int ST_W = 5;

    chd_state_t state_q, state_d;
    logic [7:0]        op_q;
    chd_op_t           cls;
    logic [AW-1:0]     idx_q;
    logic [CODE_W-1:0] tmp_q;
    logic [ST_W-1:0]   status_q;
    logic [7:0]        result_q;

    logic              mem_we;
    logic [AW-1:0]     mem_waddr;
    logic [CODE_W-1:0] mem_wdata;
    logic [AW-1:0]     rd_b_addr;
    logic [CODE_W-1:0] rd_a_data, rd_b_data;
    logic              cur_load, cur_step, cur_up;
    logic [AW-1:0]     cur_q;
    logic              go_left, is_rot;

    chd_decode u_dec (.op(op_q), .cls(cls));

    chd_cursor #(.DEPTH(DEPTH)) u_cur (
        .clk(clk), .rst_n(rst_n),
        .load(cur_load), .load_val(op_q[AW-1:0]),
        .step(cur_step), .up(cur_up),
        .cur(cur_q)
    );

    chd_charmem #(.DEPTH(DEPTH), .CODE_W(CODE_W)) u_mem (
        .clk(clk), .rst_n(rst_n),
        .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
        .raddr_a(cur_q), .rdata_a(rd_a_data),
        .raddr_b(rd_b_addr), .rdata_b(rd_b_data)
    );

    assign go_left = (cls == OP_ROT_L) || (cls == OP_SHF_L);
    assign is_rot  = (cls == OP_ROT_L) || (cls == OP_ROT_R);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and per-state control outputs
    always_comb begin
        state_d   = state_q;
        mem_we    = 1'b0;
        mem_waddr = idx_q;
        mem_wdata = '0;
        rd_b_addr = idx_q;
        cur_load  = 1'b0;
        cur_step  = 1'b0;
        cur_up    = status_q[0];
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_valid) state_d = ST_DISPATCH;
            end
            ST_DISPATCH: begin
                unique case (cls)
                    OP_PUT: begin
                        mem_we    = 1'b1;
                        mem_waddr = cur_q;
                        mem_wdata = op_q[CODE_W-1:0];
                        cur_step  = status_q[1];
                        state_d   = ST_FINISH;
                    end
                    OP_WIPE, OP_BLANKFILL: state_d = ST_FILL;
                    OP_ROT_L, OP_SHF_L: begin
                        rd_b_addr = '0;
                        state_d   = ST_MOVE;
                    end
                    OP_ROT_R, OP_SHF_R: begin
                        rd_b_addr = LAST_IDX;
                        state_d   = ST_MOVE;
                    end
                    OP_CUR_UP: begin
                        cur_step = 1'b1;
                        cur_up   = 1'b1;
                        state_d  = ST_FETCH;
                    end
                    OP_CUR_DN: begin
                        cur_step = 1'b1;
                        cur_up   = 1'b0;
                        state_d  = ST_FETCH;
                    end
                    OP_READ: begin
                        cur_step = status_q[1];
                        state_d  = ST_FETCH;
                    end
                    OP_SEEK: begin
                        cur_load = 1'b1;
                        state_d  = ST_FETCH;
                    end
                    default: state_d = ST_FINISH;
                endcase
            end
            ST_FILL: begin
                mem_we    = 1'b1;
                mem_wdata = (cls == OP_WIPE) ? '0 : BLANK_CODE;
                if (idx_q == LAST_IDX) state_d = ST_FINISH;
            end
            ST_MOVE: begin
                mem_we    = 1'b1;
                rd_b_addr = go_left ? idx_q + AW'(1) : idx_q - AW'(1);
                mem_wdata = rd_b_data;
                if ((go_left && idx_q == PENULT) || (!go_left && idx_q == AW'(1)))
                    state_d = ST_TAIL;
            end
            ST_TAIL: begin
                mem_we    = 1'b1;
                mem_waddr = go_left ? LAST_IDX : '0;
                mem_wdata = is_rot ? tmp_q : BLANK_CODE;
                state_d   = ST_FINISH;
            end
            ST_FETCH:  state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q     <= '0;
            idx_q    <= '0;
            tmp_q    <= '0;
            status_q <= '0;
            result_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (cmd_valid) op_q <= cmd_byte;
                end
                ST_DISPATCH: begin
                    idx_q <= (cls == OP_ROT_R || cls == OP_SHF_R) ? LAST_IDX : '0;
                    tmp_q <= rd_b_data;
                    unique case (cls)
                        OP_SETSTAT: status_q <= op_q[ST_W-1:0];
                        OP_LEN:     result_q <= 8'(LAST_IDX);
                        OP_STAT:    result_q <= 8'(status_q);
                        OP_WHERE:   result_q <= 8'(cur_q);
                        default:    ;
                    endcase
                end
                ST_FILL:  idx_q <= idx_q + AW'(1);
                ST_MOVE:  idx_q <= go_left ? idx_q + AW'(1) : idx_q - AW'(1);
                ST_FETCH: result_q <= 8'(rd_a_data);
                default:  ;
            endcase
        end
    end

    assign busy   = (state_q != ST_IDLE);
    assign done   = (state_q == ST_FINISH);
    assign result = result_q;

endmodule

// File: rtl/chd_checker.sv
module chd_checker #(
    parameter int AW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmd_valid,
    input logic          busy,
    input logic          done,
    input logic [7:0]    result,
    input logic [AW-1:0] cursor
);
    AST_DONE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R3

    AST_DONE_RELEASES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy); // R2

    AST_ACCEPT_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_valid) |=> busy); // R2

    AST_IDLE_CURSOR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !cmd_valid) |=> $stable(cursor)); // R13

    AST_RESULT_MOVES_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result) |-> busy); // R12

    AST_DONE_QUIET_AFTER: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> ($stable(result) && $stable(cursor))); // R3
endmodule

bind chd_cmd_engine chd_checker #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid),
    .busy(busy), .done(done), .result(result), .cursor(cur_q)
);

// File: tb/chd_cmd_engine_tb.sv
module chd_cmd_engine_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [7:0] cmd_byte = 8'h00;
    logic       busy, done;
    logic [7:0] result;

    int n_chk = 0;
    int n_fail = 0;

    logic [5:0] m [32];
    int         cur = 0;
    logic [4:0] st = 5'd0;
    logic [7:0] last_res = 8'h00;

    always #10 clk = ~clk;

    chd_cmd_engine u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
        .busy(busy), .done(done), .result(result)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int stepped(input int c, input bit up);
        return up ? (c + 1) % 32 : (c + 31) % 32;
    endfunction

    task automatic model(input logic [7:0] b, output int res, output int lat);
        logic [5:0] t;
        lat = 2;
        casez (b)
            8'hE0: begin for (int i = 0; i < 32; i++) m[i] = 6'h00; lat = 34; end
            8'hE1: begin for (int i = 0; i < 32; i++) m[i] = 6'h20; lat = 34; end
            8'hE2: begin t = m[0]; for (int i = 0; i < 31; i++) m[i] = m[i+1]; m[31] = t; lat = 34; end
            8'hE3: begin t = m[31]; for (int i = 31; i > 0; i--) m[i] = m[i-1]; m[0] = t; lat = 34; end
            8'hE4: begin for (int i = 0; i < 31; i++) m[i] = m[i+1]; m[31] = 6'h20; lat = 34; end
            8'hE5: begin for (int i = 31; i > 0; i--) m[i] = m[i-1]; m[0] = 6'h20; lat = 34; end
            8'hE6: begin cur = stepped(cur, 1'b1); last_res = {2'b00, m[cur]}; lat = 3; end
            8'hE7: begin cur = stepped(cur, 1'b0); last_res = {2'b00, m[cur]}; lat = 3; end
            8'hEA: begin if (st[1]) cur = stepped(cur, st[0]); last_res = {2'b00, m[cur]}; lat = 3; end
            8'hEB: last_res = 8'h1F;
            8'hED: last_res = {3'b000, st};
            8'hEF: last_res = 8'(cur);
            8'b00??????: begin m[cur] = b[5:0]; if (st[1]) cur = stepped(cur, st[0]); end
            8'b100?????: begin cur = int'(b[4:0]); last_res = {2'b00, m[cur]}; lat = 3; end
            8'b110?????: st = b[4:0];
            default: ;
        endcase
        res = int'(last_res);
    endtask

    task automatic issue(input logic [7:0] b, input string tag);
        int lat, exp_res, exp_lat;
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_byte  = b;
        @(negedge clk);
        cmd_valid = 1'b0;
        lat = 1;
        while (!done && lat < 200) begin
            @(negedge clk);
            lat++;
        end
        model(b, exp_res, exp_lat);
        chk(int'(result) == exp_res, tag, int'(result), exp_res);
        chk(lat == exp_lat, "R3 latency", lat, exp_lat);
        @(negedge clk);
        chk(!done && !busy, "R2/R3 release", {done, busy}, 0);
    endtask

    task automatic dump(input string tag);
        for (int a = 0; a < 32; a++) issue(8'h80 | 8'(a), tag);
    endtask

    initial begin
        #(20 * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) m[i] = 6'h00;
        repeat (3) @(negedge clk);
        chk(!busy && !done && result == 8'h00, "R1 reset outputs", {busy, done, result}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && result == 8'h00, "R1 after release", {busy, done, result}, 0);
        issue(8'hEF, "R1 cursor");
        issue(8'hED, "R1 status");
        dump("R1 store");

        // R4 / R9: write a distinct code at every position
        for (int a = 0; a < 32; a++) begin
            issue(8'h80 | 8'(a), "R9 seek");
            issue(8'((a * 5 + 3) & 63), "R4 put");
        end
        dump("R4 readback");

        // R10: every status value round trip
        for (int v = 0; v < 32; v++) begin
            issue(8'hC0 | 8'(v), "R10 load");
            issue(8'hED, "R10 read");
        end

        // R4 index up with wrap
        issue(8'hC3, "R10 index up");
        issue(8'h80 | 8'd30, "R9 seek");
        for (int k = 0; k < 3; k++) issue(8'h11 + 8'(k), "R4 index up");
        issue(8'hEF, "R12 cursor after up");
        // R4 index down with wrap
        issue(8'hC2, "R10 index down");
        issue(8'h81, "R9 seek");
        for (int k = 0; k < 3; k++) issue(8'h2A + 8'(k), "R4 index down");
        issue(8'hEF, "R12 cursor after down");
        dump("R4 index readback");

        // R11 read with and without index
        issue(8'hC3, "R10");
        issue(8'h9F, "R9");
        for (int k = 0; k < 3; k++) issue(8'hEA, "R11 index read");
        issue(8'hC2, "R10");
        for (int k = 0; k < 2; k++) issue(8'hEA, "R11 index read down");
        issue(8'hC0, "R10");
        for (int k = 0; k < 2; k++) issue(8'hEA, "R11 plain read");
        issue(8'hEF, "R11 cursor held");

        // R8 cursor steps
        issue(8'h80, "R9");
        issue(8'hE7, "R8 dec wrap");
        issue(8'hE6, "R8 inc wrap");
        issue(8'hE6, "R8 inc");
        issue(8'hEF, "R8 cursor");
        issue(8'hEB, "R12 length");

        // R6 / R7 sweeps
        issue(8'hE2, "R6 rot left");  dump("R6 left");
        issue(8'hE3, "R6 rot right"); issue(8'hE3, "R6 rot right"); dump("R6 right");
        issue(8'hE4, "R7 shl");       dump("R7 left");
        issue(8'hE5, "R7 shr");       dump("R7 right");

        // R5 fills
        issue(8'hE1, "R5 blank");     dump("R5 blank");
        issue(8'h85, "R9"); issue(8'h3F, "R4");
        issue(8'hE0, "R5 clear");     dump("R5 clear");

        // R13 no-ops leave everything intact
        for (int a = 0; a < 32; a++) begin
            issue(8'h80 | 8'(a), "R9");
            issue(8'(63 - a), "R4");
        end
        issue(8'hC5, "R10");
        issue(8'h87, "R9");
        begin
            logic [7:0] nops [12] = '{8'h40, 8'h5F, 8'h60, 8'h7F, 8'hA0, 8'hB1,
                                      8'hE8, 8'hE9, 8'hEC, 8'hEE, 8'hF0, 8'hFF};
            for (int k = 0; k < 12; k++) issue(nops[k], "R13 no-op");
        end
        issue(8'hEF, "R13 cursor");
        issue(8'hED, "R13 status");
        dump("R13 store");

        // R2: commands during busy are ignored
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_byte  = 8'hE0;
        @(negedge clk);
        cmd_byte = 8'h15;
        for (int k = 0; k < 5; k++) begin
            chk(busy == 1'b1, "R2 busy held", busy, 1);
            @(negedge clk);
        end
        cmd_valid = 1'b0;
        begin
            int w = 0;
            int dummy_r, dummy_l;
            while (!done && w < 100) begin @(negedge clk); w++; end
            model(8'hE0, dummy_r, dummy_l);
        end
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk(!busy && !done, "R2 no extra command", {busy, done}, 0);
        end
        dump("R2 store");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule